// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a logical address, made of a segment number and an offset, into a physical address. The segment number selects one entry of a small on-chip segment table. Each entry describes one segment with four things: a starting physical address, a length, a valid flag, and permission bits for reading, writing and instruction fetch. A separate length register sets how many segment numbers are legal.

Software fills the table through a write port, one entry at a time, and sets the length register through its own write strobe. Each request carries an access type. The block answers one cycle after it accepts a request. The answer is either a physical address or a fault code. The fault code tells apart four cases: a segment number out of range, an invalid entry, an offset past the segment end, and an access the segment does not permit.

Requests and responses each use a valid/ready handshake. A response that the consumer has not taken stays where it is. A new request is accepted only when the response register is empty or is being drained in that same cycle.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset the response output is empty and request ready is high. The length register reads as 0 and every table entry is invalid, so every request faults until software loads the table.
- R2: A request whose segment number is not below the length register, or not below the table size (8), returns fault code 1 (length fault).
- R3: A request to an in-range segment whose entry has its valid flag clear returns fault code 2 (invalid fault).
- R4: A request whose offset is equal to or above the entry's limit returns fault code 3 (limit fault). An offset of limit minus 1 is still legal.
- R5: Access codes are 0 for read, 1 for write, 2 for execute and 3 for reserved. Permission bit 0 allows read, bit 1 allows write and bit 2 allows execute. An access whose bit is clear, or any access with code 3, returns fault code 4 (permission fault).
- R6: When several faults apply, only the first in the order length, invalid, limit, permission is reported.
- R7: A request with no fault returns fault code 0 and a physical address equal to base plus offset, truncated to the 24-bit address width.
- R8: Whenever the fault code is non-zero, the physical address output is 0.
- R9: A request accepted on a clock edge appears on the response port after that edge, so the latency is one cycle. With the consumer always ready, one request is accepted every cycle.
- R10: While a response is valid and the consumer is not ready, the response valid flag, address and fault code hold their values, and request ready is low.
- R11: A table write replaces every field of the addressed entry. A length write replaces the length register. Requests accepted after the write edge see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | 3 | Entry index to write |
| tbl_base | input | 24 | Segment start physical address |
| tbl_limit | input | 16 | Segment length |
| tbl_valid | input | 1 | Entry valid flag |
| tbl_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| len_we | input | 1 | Length register write strobe |
| len_val | input | 4 | New length register value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_seg | input | 4 | Segment number |
| req_off | input | 16 | Offset within the segment |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 24 | Physical address, 0 on any fault |
| rsp_fault | output | 3 | 0 none, 1 length, 2 invalid, 3 limit, 4 permission |

## Verification
Two situations are the hardest to reach from the ports. The first is a response held under backpressure while another request is waiting, because this needs the consumer stalled at the exact cycle a response lands. The second is a pair of faults that apply together, where only the first in priority order may be reported.

The bench reaches the stall directly: it holds the consumer's ready low, issues one request, and checks that the response stays frozen over several cycles while request ready stays low. It reaches the fault overlaps with entries set up on purpose to break several rules at once. Examples are an invalid entry addressed with an oversized offset and a reserved access code, and an out-of-range segment number combined with every other violation.

A long random stream with random consumer stalls then runs against a scoreboard model that the bench builds from the requirements.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int ACC_W  = 2;
  localparam int PERM_W = 3;

  // Fault codes, listed from highest to lowest priority after FLT_NONE
  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_LEN  = 3'd1,
    FLT_INV  = 3'd2,
    FLT_LIM  = 3'd3,
    FLT_PERM = 3'd4
  } fault_e;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_COUNT = 8,
  parameter int IDX_W     = 3,
  parameter int BASE_W    = 24,
  parameter int OFF_W     = 16,
  parameter int PERM_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [OFF_W-1:0]  wr_limit,
  input  logic              wr_valid,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BASE_W-1:0] rd_base,
  output logic [OFF_W-1:0]  rd_limit,
  output logic              rd_valid,
  output logic [PERM_W-1:0] rd_perm
);

  localparam int ENT_W = BASE_W + OFF_W + PERM_W;

  // Payload array has no reset so it can map onto distributed RAM.
  // Only the valid flags sit in flops that reset clears.
  logic [ENT_W-1:0]     data_mem [SEG_COUNT];
  logic [SEG_COUNT-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) data_mem[wr_idx] <= {wr_base, wr_limit, wr_perm};
  end

  always_ff @(posedge clk) begin
    if (rst)        valid_q         <= '0;
    else if (wr_en) valid_q[wr_idx] <= wr_valid;
  end

  assign {rd_base, rd_limit, rd_perm} = data_mem[rd_idx];
  assign rd_valid = valid_q[rd_idx];

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int SEG_COUNT = 8,
  parameter int SEGNUM_W  = 4,
  parameter int OFF_W     = 16,
  parameter int BASE_W    = 24
) (
  input  logic [SEGNUM_W-1:0] seg,
  input  logic [SEGNUM_W-1:0] len,
  input  logic [OFF_W-1:0]    off,
  input  logic [ACC_W-1:0]    acc,
  input  logic [BASE_W-1:0]   ent_base,
  input  logic [OFF_W-1:0]    ent_limit,
  input  logic                ent_valid,
  input  logic [PERM_W-1:0]   ent_perm,
  output fault_e              fault,
  output logic [BASE_W-1:0]   paddr
);

  logic in_table;

  // Bound check against the table size, needed only when the segment
  // number can name an entry past the end of the table
  generate
    if (SEG_COUNT < (2 ** SEGNUM_W)) begin : g_bound
      localparam logic [SEGNUM_W-1:0] CNT = SEGNUM_W'(SEG_COUNT);
      assign in_table = (seg < CNT);
    end else begin : g_full
      assign in_table = 1'b1;
    end
  endgenerate

  logic [(2**ACC_W)-1:0] perm_vec;
  logic                  perm_ok;
  logic [BASE_W-1:0]     sum;

  // Access code 3 indexes a constant 0, so it never passes
  assign perm_vec = {{((2**ACC_W)-PERM_W){1'b0}}, ent_perm};
  assign perm_ok  = perm_vec[acc];
  assign sum      = ent_base + BASE_W'(off);

  always_comb begin
    if (!in_table || !(seg < len)) fault = FLT_LEN;
    else if (!ent_valid)           fault = FLT_INV;
    else if (!(off < ent_limit))   fault = FLT_LIM;
    else if (!perm_ok)             fault = FLT_PERM;
    else                           fault = FLT_NONE;
  end

  assign paddr = (fault == FLT_NONE) ? sum : '0;

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int SEG_COUNT  = 8,
  parameter int SEGNUM_W   = 4,
  parameter int OFF_W      = 16,
  parameter int BASE_W     = 24,
  localparam int IDX_W     = $clog2(SEG_COUNT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tbl_we,
  input  logic [IDX_W-1:0]    tbl_idx,
  input  logic [BASE_W-1:0]   tbl_base,
  input  logic [OFF_W-1:0]    tbl_limit,
  input  logic                tbl_valid,
  input  logic [2:0]          tbl_perm,
  input  logic                len_we,
  input  logic [SEGNUM_W-1:0] len_val,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [SEGNUM_W-1:0] req_seg,
  input  logic [OFF_W-1:0]    req_off,
  input  logic [1:0]          req_acc,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [BASE_W-1:0]   rsp_paddr,
  output logic [2:0]          rsp_fault
);

  logic [SEGNUM_W-1:0] len_q;
  logic [BASE_W-1:0]   ent_base;
  logic [OFF_W-1:0]    ent_limit;
  logic                ent_valid;
  logic [PERM_W-1:0]   ent_perm;
  fault_e              fault_c;
  logic [BASE_W-1:0]   paddr_c;
  logic                accept;

  always_ff @(posedge clk) begin
    if (rst)         len_q <= '0;
    else if (len_we) len_q <= len_val;
  end

  seg_table #(
    .SEG_COUNT(SEG_COUNT), .IDX_W(IDX_W), .BASE_W(BASE_W),
    .OFF_W(OFF_W), .PERM_W(PERM_W)
  ) u_table (
    .clk(clk), .rst(rst),
    .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_base(tbl_base),
    .wr_limit(tbl_limit), .wr_valid(tbl_valid), .wr_perm(tbl_perm),
    .rd_idx(req_seg[IDX_W-1:0]),
    .rd_base(ent_base), .rd_limit(ent_limit),
    .rd_valid(ent_valid), .rd_perm(ent_perm)
  );

  seg_check #(
    .SEG_COUNT(SEG_COUNT), .SEGNUM_W(SEGNUM_W),
    .OFF_W(OFF_W), .BASE_W(BASE_W)
  ) u_check (
    .seg(req_seg), .len(len_q), .off(req_off), .acc(req_acc),
    .ent_base(ent_base), .ent_limit(ent_limit),
    .ent_valid(ent_valid), .ent_perm(ent_perm),
    .fault(fault_c), .paddr(paddr_c)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= FLT_NONE;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_paddr <= paddr_c;
      rsp_fault <= fault_c;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/seg_xlate_unit_sva.sv
module seg_xlate_unit_sva #(
  parameter int SEG_COUNT = 8,
  parameter int SEGNUM_W  = 4,
  parameter int BASE_W    = 24
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic                req_ready,
  input logic [SEGNUM_W-1:0] req_seg,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [BASE_W-1:0]   rsp_paddr,
  input logic [2:0]          rsp_fault
);

  assert_accept_latency_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  assert_idle_empty_R9: assert property (@(posedge clk) disable iff (rst)
    (!rsp_valid && !(req_valid && req_ready)) |=> !rsp_valid);

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  assert_fault_addr_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 3'd0) |-> rsp_paddr == '0);

  assert_out_of_table_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (32'(req_seg) >= SEG_COUNT)) |=> rsp_fault == 3'd1);

  assert_code_range_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_fault <= 3'd4);

endmodule

bind seg_xlate_unit seg_xlate_unit_sva #(
  .SEG_COUNT(SEG_COUNT), .SEGNUM_W(SEGNUM_W), .BASE_W(BASE_W)
) u_sva (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_seg(req_seg), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
);

// File: tb/seg_xlate_unit_test.sv
module seg_xlate_unit_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_idx = '0;
  logic [23:0] tbl_base = '0;
  logic [15:0] tbl_limit = '0;
  logic        tbl_valid = 1'b0;
  logic [2:0]  tbl_perm = '0;
  logic        len_we = 1'b0;
  logic [3:0]  len_val = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_seg = '0;
  logic [15:0] req_off = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [23:0] rsp_paddr;
  logic [2:0]  rsp_fault;

  logic bp_on = 1'b0;
  logic hold_ready = 1'b1;

  int n_chk = 0;
  int n_fail = 0;

  // Bench-side picture of the table, built from the requirements
  logic [23:0] sh_base [8];
  logic [15:0] sh_lim  [8];
  logic        sh_v    [8];
  logic [2:0]  sh_perm [8];
  logic [3:0]  sh_len;

  logic [23:0] q_pa  [$];
  logic [2:0]  q_ft  [$];
  string       q_tag [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate_unit uut (
    .clk(clk), .rst(rst),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_base(tbl_base),
    .tbl_limit(tbl_limit), .tbl_valid(tbl_valid), .tbl_perm(tbl_perm),
    .len_we(len_we), .len_val(len_val),
    .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
    .req_off(req_off), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Consumer ready: either random stalls or a level set by the main flow
  always @(posedge clk) begin
    #2;
    rsp_ready = bp_on ? (($urandom % 4) != 0) : hold_ready;
  end

  // Monitor: a transfer happens at the next edge when both are high
  always @(negedge clk) begin
    if (!rst && rsp_valid && rsp_ready) begin
      if (q_pa.size() == 0) begin
        check(1'b0, "R9", "unexpected response", 1, 0);
      end else begin
        automatic logic [23:0] epa = q_pa.pop_front();
        automatic logic [2:0]  eft = q_ft.pop_front();
        automatic string       tg  = q_tag.pop_front();
        check(rsp_fault == eft, tg, "fault code", rsp_fault, eft);
        check(rsp_paddr == epa, tg, "phys addr", rsp_paddr, epa);
      end
    end
  end

  function automatic void model(input logic [3:0] seg, input logic [15:0] off,
                                input logic [1:0] acc,
                                output logic [23:0] pa, output logic [2:0] ft);
    pa = '0;
    if (seg >= sh_len || seg >= 4'd8)          ft = 3'd1;
    else if (!sh_v[seg[2:0]])                  ft = 3'd2;
    else if (off >= sh_lim[seg[2:0]])          ft = 3'd3;
    else if (acc == 2'd3 || !sh_perm[seg[2:0]][acc]) ft = 3'd4;
    else begin
      ft = 3'd0;
      pa = sh_base[seg[2:0]] + {8'd0, off};
    end
  endfunction

  task automatic send(input logic [3:0] seg, input logic [15:0] off,
                      input logic [1:0] acc, input string tag);
    logic [23:0] pa;
    logic [2:0]  ft;
    model(seg, off, acc, pa, ft);
    @(posedge clk); #1;
    req_valid = 1'b1; req_seg = seg; req_off = off; req_acc = acc;
    do @(negedge clk); while (!req_ready);
    q_pa.push_back(pa); q_ft.push_back(ft); q_tag.push_back(tag);
  endtask

  task automatic tbl_write(input logic [2:0] idx, input logic [23:0] b,
                           input logic [15:0] l, input logic v, input logic [2:0] p);
    @(posedge clk); #1;
    req_valid = 1'b0;
    tbl_we = 1'b1; tbl_idx = idx; tbl_base = b; tbl_limit = l;
    tbl_valid = v; tbl_perm = p;
    sh_base[idx] = b; sh_lim[idx] = l; sh_v[idx] = v; sh_perm[idx] = p;
    @(posedge clk); #1;
    tbl_we = 1'b0;
  endtask

  task automatic set_len(input logic [3:0] v);
    @(posedge clk); #1;
    req_valid = 1'b0;
    len_we = 1'b1; len_val = v; sh_len = v;
    @(posedge clk); #1;
    len_we = 1'b0;
  endtask

  task automatic go_idle();
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "R9", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [23:0] cap_pa;
    logic [2:0]  cap_ft;
    for (int i = 0; i < 8; i++) begin
      sh_base[i] = '0; sh_lim[i] = '0; sh_v[i] = 1'b0; sh_perm[i] = '0;
    end
    sh_len = '0;

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);

    // R1: length 0 after reset, so even segment 0 faults
    send(4'd0, 16'd0, 2'd0, "R1");
    // R1 / R3: length opened but entries still invalid from reset
    set_len(4'd8);
    send(4'd5, 16'd0, 2'd0, "R3");

    // Perm bits: bit0 read, bit1 write, bit2 execute
    tbl_write(3'd0, 24'h100000, 16'h1000, 1'b1, 3'b111);
    tbl_write(3'd1, 24'h200000, 16'h0010, 1'b1, 3'b001);
    tbl_write(3'd2, 24'hFFFFF0, 16'h0040, 1'b1, 3'b100);
    tbl_write(3'd3, 24'h300000, 16'h0100, 1'b0, 3'b111);
    tbl_write(3'd5, 24'h050000, 16'h0800, 1'b1, 3'b010);

    send(4'd0, 16'h0123, 2'd0, "R7");
    send(4'd0, 16'h0FFF, 2'd1, "R4");   // limit minus 1 is legal
    send(4'd0, 16'h1000, 2'd0, "R4");   // offset equal to limit
    send(4'd2, 16'h0020, 2'd2, "R7");   // wraps to 0x000010
    send(4'd1, 16'h0004, 2'd1, "R5");   // write to read-only
    send(4'd5, 16'h0004, 2'd0, "R5");   // read to write-only
    send(4'd5, 16'h0004, 2'd1, "R7");
    send(4'd0, 16'h0004, 2'd3, "R5");   // reserved access code
    send(4'd2, 16'h0004, 2'd0, "R5");
    send(4'd3, 16'h0004, 2'd0, "R3");
    send(4'd9, 16'h0004, 2'd0, "R2");   // beyond table size
    send(4'd3, 16'hFFFF, 2'd3, "R6");   // invalid beats limit and perm
    send(4'd1, 16'h0020, 2'd1, "R6");   // limit beats perm
    set_len(4'd2);
    send(4'd2, 16'h0004, 2'd2, "R2");   // now past length register
    send(4'd4, 16'hFFFF, 2'd3, "R6");   // length beats all others
    send(4'd1, 16'h0004, 2'd0, "R8");

    // R11: rewrite entry 1 and widen length again
    set_len(4'd8);
    tbl_write(3'd1, 24'h0A0000, 16'h0200, 1'b1, 3'b011);
    send(4'd1, 16'h0100, 2'd1, "R11");
    tbl_write(3'd0, 24'h100000, 16'h1000, 1'b0, 3'b111);
    send(4'd0, 16'h0004, 2'd0, "R11");
    tbl_write(3'd0, 24'h100000, 16'h1000, 1'b1, 3'b111);
    go_idle();
    repeat (2) @(posedge clk);

    // R9 / R10: stall the consumer, then release
    #1 hold_ready = 1'b0;
    send(4'd0, 16'h0040, 2'd0, "R10");
    @(posedge clk); #1;
    req_valid = 1'b1; req_seg = 4'd1; req_off = 16'h0001; req_acc = 2'd0;
    @(negedge clk);
    check(rsp_valid == 1'b1, "R9", "response one cycle after accept", rsp_valid, 1);
    check(req_ready == 1'b0, "R10", "req_ready while stalled", req_ready, 0);
    cap_pa = rsp_paddr; cap_ft = rsp_fault;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(rsp_valid && rsp_paddr == cap_pa && rsp_fault == cap_ft,
            "R10", "held response", rsp_paddr, cap_pa);
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    hold_ready = 1'b1;
    repeat (3) @(posedge clk);

    // R9: back-to-back acceptance with consumer ready
    send(4'd0, 16'h0001, 2'd0, "R9");
    send(4'd0, 16'h0002, 2'd0, "R9");
    check(req_ready == 1'b1, "R9", "ready during stream", req_ready, 1);
    send(4'd0, 16'h0003, 2'd2, "R9");
    go_idle();

    // Random stream under random stalls, all fault orderings
    bp_on = 1'b1;
    for (int n = 0; n < 200; n++) begin
      send(4'($urandom % 16), 16'($urandom % 16'h0050), 2'($urandom % 4), "R6");
      if (n == 100) set_len(4'd6);
    end
    go_idle();
    bp_on = 1'b0;
    repeat (8) @(posedge clk);
    check(q_pa.size() == 0, "R9", "responses outstanding", q_pa.size(), 0);
    finish_run();
  end

endmodule